// File: doc/BRIEF.md
# Linear Sweep Ramp Generator

This block generates a control word that ramps in straight-line steps, for use as the frequency, phase or amplitude input of a direct digital synthesizer. A single profile input decides the direction. When it goes high, the word climbs from its present value toward an end word. When it goes low, the word descends toward a start word. Each direction has its own step size (delta word) and its own dwell interval (ramp-rate word). The dwell interval is counted in clock cycles.

A kind select picks the width of the swept quantity. Every operand is cut to that width, and the output never leaves it. Each step is clamped at its target, so the ramp lands exactly on the end or start word even when the delta does not divide the span. A no-dwell option sends the word back to the start word after an upward ramp completes. Delta and rate words may be changed while a ramp runs, which gives piecewise or curved sweeps.

Top module: `lin_sweep_gen`

## Requirements
- R1: After reset the output word is 0 and the done flag is 0.
- R2: The kind select sets the width of the swept word. Kind 0 selects frequency, 32 bits. Kind 1 selects phase, 14 bits. Kind 2 selects amplitude, 10 bits. Kind 3 is treated as frequency. The output is always the stored word masked to the selected width.
- R3: The profile input passes through two synchronizing flops. A low-to-high change is acted on at the third rising clock edge after the change. That edge loads the rising rate into the step timer, and the word then rises by the rising delta every R cycles. R is the rising rate. The first step comes R cycles after the load.
- R4: A high-to-low profile change is handled in the same way. It uses the falling delta and the falling rate, and the word then descends.
- R5: An upward ramp stops exactly at the end word and never passes it. Done goes to 1 on the same edge, and the word then holds.
- R6: A downward ramp stops exactly at the start word and never goes below it. Done goes to 1, and the word then holds.
- R7: A rate word of 0 steps every cycle, as a rate of 1 does. A rate word of 255 holds each value for 255 cycles.
- R8: This requirement applies when the no-dwell input is 1. When an upward ramp lands on the end word, the word moves to the start word on the next edge. Done goes to 1 on that same edge.
- R9: A delta word written during a ramp is used from the next step onward. A rate word written during a ramp is used from the next timer reload onward.
- R10: A profile change during a ramp reverses the direction from the present word. The load edge itself takes no step.
- R11: Done goes to 0 on the load edge of every profile change.
- R12: No step wraps around. A rising ramp whose end word is at full scale for the selected width settles at full scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sweep clock |
| rst_n | input | 1 | Synchronous active-low reset |
| profile_i | input | 1 | Direction control; may be asynchronous |
| sweep_kind_i | input | 2 | 0 frequency, 1 phase, 2 amplitude, 3 frequency |
| no_dwell_i | input | 1 | Return to the start word after an upward ramp |
| start_word_i | input | 32 | Lower target word |
| end_word_i | input | 32 | Upper target word |
| rise_delta_i | input | 32 | Step size while rising |
| fall_delta_i | input | 32 | Step size while falling |
| rise_rate_i | input | 8 | Cycles per step while rising |
| fall_rate_i | input | 8 | Cycles per step while falling |
| sweep_word_o | output | 32 | Current swept word, masked to the selected width |
| sweep_done_o | output | 1 | Word is resting at the target of the current direction |

## Verification
The load edge falls three rising edges after a profile change: two edges pass through the synchronizer and the third captures the change. The first step then lands R edges after the load, and each later step R edges after the one before it. Every directed scenario records the cycle count at the moment it drives the profile, and samples on falling edges at offsets computed from that count. Results are checked exactly on the due edge and on the edge just before it. When a delta or rate changes mid-ramp, the expected value accounts for the timer reload that was already pending. A reversal that arrives while a step is also due is checked on the edge where the load wins.

// File: rtl/lsg_pkg.sv
package lsg_pkg;

    // Kind of quantity being swept; selects the active word width.
    typedef enum logic [1:0] {
        KIND_FREQ  = 2'd0,
        KIND_PHASE = 2'd1,
        KIND_AMPL  = 2'd2,
        KIND_FREQ2 = 2'd3
    } sweep_kind_e;

endpackage

// File: rtl/lsg_profile_sync.sv
// Two-flop synchronizer for the profile input, followed by edge detection.
// Assumes: profile_async may change at any time; edges are reported one
// cycle wide, on the cycle after the second flop takes the new level.
module lsg_profile_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic profile_async,
    output logic rise_o,
    output logic fall_o
);
    logic meta_q, stable_q, last_q;

    // Resolve metastability and keep the previous synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= 1'b0;
            stable_q <= 1'b0;
            last_q   <= 1'b0;
        end else begin
            meta_q   <= profile_async;
            stable_q <= meta_q;
            last_q   <= stable_q;
        end
    end

    // Compare the current synchronized level with the previous one.
    always_comb begin
        rise_o = stable_q & ~last_q;
        fall_o = ~stable_q & last_q;
    end
endmodule

// File: rtl/lsg_step_timer.sv
// Dwell counter. It fires one tick each time the present value has been
// held for the selected number of cycles. A rate of zero behaves as one.
// Assumes: load_i has priority, and no tick is produced on a load cycle.
// The rate is read again at every reload.
module lsg_step_timer #(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              run_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              tick_o
);
    logic [RATE_W-1:0] cnt_q;
    logic [RATE_W-1:0] reload_val;

    // Reload value is the rate minus one, with zero clamped to zero.
    always_comb begin
        reload_val = (rate_i == '0) ? '0 : rate_i - RATE_W'(1);
    end

    // A tick is due when the counter has run down while the ramp is active.
    always_comb begin
        tick_o = run_i && !load_i && (cnt_q == '0);
    end

    // Count down, and reload on a load or after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= reload_val;
        end else if (run_i) begin
            if (cnt_q == '0) cnt_q <= reload_val;
            else             cnt_q <= cnt_q - RATE_W'(1);
        end
    end

    // After a tick with a rate above one, the next cycle cannot tick.
    p_tick_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && rate_i > RATE_W'(1)) |=> !tick_o);
endmodule

// File: rtl/lsg_width_mask.sv
// Turns the sweep kind into a mask that covers the active word width.
// Assumes: every width is at most WORD_W; kind 3 aliases frequency.
module lsg_width_mask
    import lsg_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int FREQ_W  = 32,
    parameter int PHASE_W = 14,
    parameter int AMPL_W  = 10
) (
    input  logic [1:0]        kind_i,
    output logic [WORD_W-1:0] mask_o
);
    localparam logic [WORD_W-1:0] FREQ_MASK  = {WORD_W{1'b1}} >> (WORD_W - FREQ_W);
    localparam logic [WORD_W-1:0] PHASE_MASK = {WORD_W{1'b1}} >> (WORD_W - PHASE_W);
    localparam logic [WORD_W-1:0] AMPL_MASK  = {WORD_W{1'b1}} >> (WORD_W - AMPL_W);

    // Pick the mask for the selected kind.
    always_comb begin
        unique case (sweep_kind_e'(kind_i))
            KIND_PHASE: mask_o = PHASE_MASK;
            KIND_AMPL:  mask_o = AMPL_MASK;
            default:    mask_o = FREQ_MASK;
        endcase
    end
endmodule

// File: rtl/lsg_step_calc.sv
// Works out the next swept word for one step toward the target. The step is
// clamped so that the result lands on the target and never passes it.
// Assumes: all operands are already masked; no sum or difference can wrap,
// because only the distance to the target is ever compared.
module lsg_step_calc #(
    parameter int WORD_W = 32
) (
    input  logic              up_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [WORD_W-1:0] delta_i,
    input  logic [WORD_W-1:0] low_i,
    input  logic [WORD_W-1:0] high_i,
    output logic [WORD_W-1:0] next_o,
    output logic              reached_o
);
    logic [WORD_W-1:0] gap_up, gap_dn;

    // Distance that is left to the target in each direction.
    always_comb begin
        gap_up = high_i - word_i;
        gap_dn = word_i - low_i;
    end

    // Choose a full step, or clamp to the target when the step would reach it.
    always_comb begin
        if (up_i) begin
            if (word_i >= high_i || gap_up <= delta_i) begin
                next_o    = high_i;
                reached_o = 1'b1;
            end else begin
                next_o    = word_i + delta_i;
                reached_o = 1'b0;
            end
        end else begin
            if (word_i <= low_i || gap_dn <= delta_i) begin
                next_o    = low_i;
                reached_o = 1'b1;
            end else begin
                next_o    = word_i - delta_i;
                reached_o = 1'b0;
            end
        end
    end
endmodule

// File: rtl/lin_sweep_gen.sv
// Linear sweep ramp generator. The profile level sets the direction. Each
// direction has its own delta and dwell. Every step is clamped at its target,
// and an optional no-dwell return sends the word back to the start word.
// Assumes: the start word is not above the end word for a meaningful sweep.
// The configuration inputs may change at any time.
module lin_sweep_gen #(
    parameter int FREQ_W  = 32,
    parameter int PHASE_W = 14,
    parameter int AMPL_W  = 10,
    parameter int RATE_W  = 8,
    localparam int WORD_W = FREQ_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              profile_i,
    input  logic [1:0]        sweep_kind_i,
    input  logic              no_dwell_i,
    input  logic [WORD_W-1:0] start_word_i,
    input  logic [WORD_W-1:0] end_word_i,
    input  logic [WORD_W-1:0] rise_delta_i,
    input  logic [WORD_W-1:0] fall_delta_i,
    input  logic [RATE_W-1:0] rise_rate_i,
    input  logic [RATE_W-1:0] fall_rate_i,
    output logic [WORD_W-1:0] sweep_word_o,
    output logic              sweep_done_o
);
    logic              rise, fall, prof_edge, tick;
    logic [WORD_W-1:0] mask, start_m, end_m, delta_m, word_m, next_word;
    logic              reached;
    logic [RATE_W-1:0] rate_sel;
    logic [WORD_W-1:0] word_q;
    logic              active_q, dir_up_q, done_q, snap_q;

    lsg_profile_sync u_sync (
        .clk           (clk),
        .rst_n         (rst_n),
        .profile_async (profile_i),
        .rise_o        (rise),
        .fall_o        (fall)
    );

    lsg_width_mask #(
        .WORD_W  (WORD_W),
        .FREQ_W  (FREQ_W),
        .PHASE_W (PHASE_W),
        .AMPL_W  (AMPL_W)
    ) u_mask (
        .kind_i (sweep_kind_i),
        .mask_o (mask)
    );

    // Edge flag, and the rate for the present (or newly captured) direction.
    always_comb begin
        prof_edge = rise | fall;
        if (prof_edge) rate_sel = rise ? rise_rate_i : fall_rate_i;
        else           rate_sel = dir_up_q ? rise_rate_i : fall_rate_i;
    end

    lsg_step_timer #(
        .RATE_W (RATE_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (prof_edge),
        .run_i  (active_q),
        .rate_i (rate_sel),
        .tick_o (tick)
    );

    // Cut every operand to the width of the selected kind.
    always_comb begin
        start_m = start_word_i & mask;
        end_m   = end_word_i & mask;
        word_m  = word_q & mask;
        delta_m = (dir_up_q ? rise_delta_i : fall_delta_i) & mask;
    end

    lsg_step_calc #(
        .WORD_W (WORD_W)
    ) u_calc (
        .up_i      (dir_up_q),
        .word_i    (word_m),
        .delta_i   (delta_m),
        .low_i     (start_m),
        .high_i    (end_m),
        .next_o    (next_word),
        .reached_o (reached)
    );

    // Sweep control: capture edges, take steps, finish or snap back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q   <= '0;
            active_q <= 1'b0;
            dir_up_q <= 1'b0;
            done_q   <= 1'b0;
            snap_q   <= 1'b0;
        end else if (prof_edge) begin
            dir_up_q <= rise;
            active_q <= 1'b1;
            done_q   <= 1'b0;
            snap_q   <= 1'b0;
        end else if (snap_q) begin
            word_q <= start_m;
            snap_q <= 1'b0;
            done_q <= 1'b1;
        end else if (tick) begin
            word_q <= next_word;
            if (reached) begin
                active_q <= 1'b0;
                if (dir_up_q && no_dwell_i) snap_q <= 1'b1;
                else                        done_q <= 1'b1;
            end
        end
    end

    // Drive the output ports.
    always_comb begin
        sweep_word_o = word_q & mask;
        sweep_done_o = done_q;
    end

    // Done drops on the load edge of every profile change.
    p_done_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        prof_edge |=> !sweep_done_o);

    // Once done, the stored word stays still until the next profile edge.
    p_hold_when_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_done_o && !prof_edge) |=> $stable(word_q));

    // A rising step never goes past the end word.
    p_no_overshoot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && dir_up_q && word_m <= end_m) |=> (word_q <= $past(end_m)));

    // A falling step never goes below the start word.
    p_no_undershoot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !dir_up_q && word_m >= start_m) |=> (word_q >= $past(start_m)));

    // A step never writes bits outside the selected width.
    p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> ((word_q & ~$past(mask)) == '0));
endmodule

// File: tb/tb_lin_sweep_gen.sv
`timescale 1ns/1ps
module tb_lin_sweep_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        profile = 1'b0;
    logic [1:0]  kind = 2'd0;
    logic        no_dwell = 1'b0;
    logic [31:0] start_w = 32'd100, end_w = 32'd1000;
    logic [31:0] rdelta = 32'd100, fdelta = 32'd300;
    logic [7:0]  rrate = 8'd2, frate = 8'd1;
    logic [31:0] word;
    logic        done;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    int t0 = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lin_sweep_gen dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .profile_i    (profile),
        .sweep_kind_i (kind),
        .no_dwell_i   (no_dwell),
        .start_word_i (start_w),
        .end_word_i   (end_w),
        .rise_delta_i (rdelta),
        .fall_delta_i (fdelta),
        .rise_rate_i  (rrate),
        .fall_rate_i  (frate),
        .sweep_word_o (word),
        .sweep_done_o (done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc - t0);
        end
    endtask

    // Drive the profile on a falling edge and mark the reference cycle.
    task automatic set_profile(input logic v);
        profile = v;
        t0 = cyc;
    endtask

    // Wait until the state after rising edge k (counted from t0) is visible.
    task automatic at_rel(input int k);
        while ((cyc - t0) < k) @(negedge clk);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 word", word, 32'd0);
        chk("R1 done", {31'd0, done}, 32'd0);
    endtask

    task automatic t_rise;
        set_profile(1'b1);
        at_rel(3);  chk("R3 no step at load", word, 32'd0);
        at_rel(4);  chk("R3 held for rate", word, 32'd0);
        at_rel(5);  chk("R3 first step", word, 32'd100);
        at_rel(7);  chk("R3 second step", word, 32'd200);
        at_rel(22); chk("R5 before end", word, 32'd900);
        chk("R5 not done yet", {31'd0, done}, 32'd0);
        at_rel(23); chk("R5 lands on end", word, 32'd1000);
        chk("R5 done", {31'd0, done}, 32'd1);
        at_rel(40); chk("R5 holds", word, 32'd1000);
    endtask

    task automatic t_fall;
        set_profile(1'b0);
        at_rel(3); chk("R11 done cleared", {31'd0, done}, 32'd0);
        chk("R4 no step at load", word, 32'd1000);
        at_rel(4); chk("R4 first down step", word, 32'd700);
        at_rel(6); chk("R6 clamps at start", word, 32'd100);
        chk("R6 done", {31'd0, done}, 32'd1);
    endtask

    task automatic t_rate_zero;
        end_w = 32'd300; rdelta = 32'd50; rrate = 8'd0;
        set_profile(1'b1);
        at_rel(4); chk("R7 rate 0 steps each cycle", word, 32'd150);
        at_rel(5); chk("R7 rate 0 next step", word, 32'd200);
        at_rel(7); chk("R7 reaches end", word, 32'd300);
    endtask

    task automatic t_rate_max;
        frate = 8'd255; fdelta = 32'd100;
        set_profile(1'b0);
        at_rel(257); chk("R7 rate 255 still held", word, 32'd300);
        at_rel(258); chk("R7 rate 255 step", word, 32'd200);
        at_rel(513); chk("R6 down to start", word, 32'd100);
    endtask

    task automatic t_no_dwell;
        no_dwell = 1'b1; rdelta = 32'd100; rrate = 8'd1;
        set_profile(1'b1);
        at_rel(4); chk("R8 step", word, 32'd200);
        at_rel(5); chk("R8 touches end", word, 32'd300);
        chk("R8 not done on touch", {31'd0, done}, 32'd0);
        at_rel(6); chk("R8 snaps to start", word, 32'd100);
        chk("R8 done after snap", {31'd0, done}, 32'd1);
        at_rel(10); chk("R8 stays at start", word, 32'd100);
    endtask

    task automatic t_rewrite;
        no_dwell = 1'b0; frate = 8'd1;
        set_profile(1'b0);
        at_rel(5);
        start_w = 32'd0; end_w = 32'd10000; rdelta = 32'd10; rrate = 8'd1;
        set_profile(1'b1);
        at_rel(5); chk("R9 small steps", word, 32'd120);
        rdelta = 32'd1000;
        at_rel(6); chk("R9 new delta used", word, 32'd1120);
        rrate = 8'd3;
        at_rel(7); chk("R9 pending reload kept", word, 32'd2120);
        at_rel(9); chk("R9 new rate holds", word, 32'd2120);
        at_rel(10); chk("R9 new rate step", word, 32'd3120);
    endtask

    task automatic t_reverse;
        fdelta = 32'd500; frate = 8'd1;
        set_profile(1'b0);
        at_rel(3); chk("R10 load edge takes no step", word, 32'd3120);
        at_rel(4); chk("R10 reverses from current", word, 32'd2620);
        at_rel(5); chk("R10 keeps falling", word, 32'd2120);
        at_rel(12); chk("R6 reaches start 0", word, 32'd0);
    endtask

    task automatic t_width;
        kind = 2'd1; end_w = 32'hFFFF_FFFF; rdelta = 32'd5000; rrate = 8'd1;
        set_profile(1'b1);
        at_rel(6); chk("R2 phase ramp", word, 32'd15000);
        at_rel(7); chk("R12 phase settles at full scale", word, 32'd16383);
        chk("R12 done", {31'd0, done}, 32'd1);
        kind = 2'd2;
        @(negedge clk); chk("R2 amplitude mask", word, 32'd1023);
        kind = 2'd3;
        @(negedge clk); chk("R2 kind 3 as frequency", word, 32'd16383);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_rise();
        t_fall();
        t_rate_zero();
        t_rate_max();
        t_no_dwell();
        t_rewrite();
        t_reverse();
        t_width();
        finish_run();
    end
endmodule